// File: doc/BRIEF.md
# Multi-Drop Serial Receiver with Address Filtering

This block is an asynchronous serial receiver for a shared bus on which one controller talks to several listeners. It takes the line state and a tick that runs at sixteen times the bit rate. It assembles frames of five to nine data bits, least significant bit first, and hands each accepted frame to the host as a byte, a ninth bit and a framing-error flag. A ready flag signals the frame, and the host clears that flag with a read strobe.

Every frame carries a type bit. In nine-bit mode the type bit is the ninth data bit. In five- to eight-bit mode it is the first stop bit. A type bit of one means the frame is an address and a zero means it carries data. While the filter is on, the receiver throws data frames away without a trace, so a listener sees only addresses. When a listener finds its own address it switches the filter off and takes the data frames that follow. It switches the filter back on after the last frame of its message. The host does the address comparison.

Top module: `uart_addr_rx`

## Requirements
- R1: After reset, rx_ready, rx_ovr, rx_ferr, rx_bit9 and filt_on are 0 and rx_data is 0.
- R2: cfg_bits selects 5 to 9 data bits (values below 5 act as 5, values above 9 act as 9). Bits are received least significant first. Bits of rx_data at and above the character size read 0.
- R3: In 9-bit mode rx_bit9 carries the ninth received bit. In 5- to 8-bit mode rx_bit9 reads 0.
- R4: With filt_on at 0, every complete frame is stored and sets rx_ready, whatever its type bit.
- R5: With filt_on at 1, a frame whose type bit is 0 is discarded. rx_data, rx_bit9 and rx_ferr keep their values and rx_ready is not set. The type bit is the ninth data bit in 9-bit mode and the first stop bit otherwise.
- R6: With filt_on at 1, a frame whose type bit is 1 is stored and sets rx_ready.
- R7: A filt_set pulse makes filt_on 1 and a filt_clr pulse makes it 0. When both arrive in the same cycle, the clear wins.
- R8: A first stop bit sampled low sets rx_ferr for the stored frame in 9-bit mode, and in 5- to 8-bit mode while the filter is off. A stop bit sampled high stores rx_ferr as 0.
- R9: An accepted frame that completes while rx_ready is 1 and no read is strobed sets rx_ovr, and rx_data keeps the older frame.
- R10: rd_stb clears rx_ready and rx_ovr in the following cycle, unless a frame is accepted in that same cycle.
- R11: A low pulse on rxd that is gone by the start-bit midpoint (8 ticks) starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial line, idle high |
| tick | input | 1 | Enable at 16 times the bit rate |
| cfg_bits | input | 4 | Number of data bits, 5 to 9 |
| filt_set | input | 1 | Pulse that turns the filter on |
| filt_clr | input | 1 | Pulse that turns the filter off |
| filt_on | output | 1 | Filter state |
| rd_stb | input | 1 | Host read strobe |
| rx_data | output | 8 | Received data byte |
| rx_bit9 | output | 1 | Ninth data bit |
| rx_ferr | output | 1 | Framing error of the stored frame |
| rx_ready | output | 1 | Frame waiting to be read |
| rx_ovr | output | 1 | An accepted frame was lost |

## Verification
The bench sends data frames and address frames with the filter on, in both the nine-bit and the eight-bit form. A receiver that takes the type bit from the wrong place either stores data frames it should drop or loses addresses. The bench sends a low first stop bit while the filter is on in eight-bit mode, and a receiver that treats this as a framing error or as the start of a new frame shows a wrong flag or a phantom frame. Back-to-back frames without a read show whether an overrun overwrites the held byte. A set and a clear of the filter in the same cycle, together with a short glitch on an idle line, expose a wrong priority and a start that is not checked at its midpoint.

// File: rtl/uart_addr_rx.sv
module uart_addr_rx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic       tick,
  input  logic [3:0] cfg_bits,
  input  logic       filt_set,
  input  logic       filt_clr,
  output logic       filt_on,
  input  logic       rd_stb,
  output logic [7:0] rx_data,
  output logic       rx_bit9,
  output logic       rx_ferr,
  output logic       rx_ready,
  output logic       rx_ovr
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_STOP, S_WAIT} st_t;
  st_t st;

  logic [CW-1:0] cnt;
  logic [3:0]    idx;
  logic [8:0]    sh;
  logic [3:0]    nb;
  logic          nine, at_last, fin, ftype, acc, ferr_now;

  assign nb       = (cfg_bits < 4'd5) ? 4'd5 : (cfg_bits > 4'd9) ? 4'd9 : cfg_bits;
  assign nine     = (nb == 4'd9);
  assign at_last  = tick && (cnt == LAST);
  assign fin      = (st == S_STOP) && at_last;
  assign ftype    = nine ? sh[8] : rxd;
  assign acc      = fin && (!filt_on || ftype);
  assign ferr_now = !rxd && (nine || !filt_on);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
      idx <= '0;
      sh  <= '0;
    end else begin
      case (st)
        S_IDLE: if (tick && !rxd) begin
          st  <= S_START;
          cnt <= '0;
        end
        S_START: if (tick) begin
          if (cnt == MID) begin
            if (!rxd) begin
              st  <= S_DATA;
              cnt <= '0;
              idx <= '0;
              sh  <= '0;
            end else begin
              st <= S_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DATA: if (tick) begin
          if (cnt == LAST) begin
            sh[idx] <= rxd;
            cnt     <= '0;
            if (idx == nb - 4'd1) st <= S_STOP;
            else idx <= idx + 4'd1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_STOP: if (tick) begin
          cnt <= at_last ? '0 : cnt + 1'b1;
          if (at_last) st <= S_WAIT;
        end
        S_WAIT: if (tick && rxd) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) filt_on <= 1'b0;
    else if (filt_clr) filt_on <= 1'b0;
    else if (filt_set) filt_on <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_bit9  <= 1'b0;
      rx_ferr  <= 1'b0;
      rx_ready <= 1'b0;
      rx_ovr   <= 1'b0;
    end else begin
      if (rd_stb) begin
        rx_ready <= 1'b0;
        rx_ovr   <= 1'b0;
      end
      if (acc) begin
        if (rx_ready && !rd_stb) begin
          rx_ovr <= 1'b1;
        end else begin
          rx_data  <= sh[7:0];
          rx_bit9  <= nine & sh[8];
          rx_ferr  <= ferr_now;
          rx_ready <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uart_addr_rx_chk.sv
module uart_addr_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] cfg_bits,
  input logic       filt_clr,
  input logic       filt_on,
  input logic       rd_stb,
  input logic [7:0] rx_data,
  input logic       rx_bit9,
  input logic       rx_ready,
  input logic       rx_ovr,
  input logic       fin,
  input logic       ftype,
  input logic       acc
);
  p_bit9_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) && ($past(cfg_bits) < 4'd9) |-> !rx_bit9);

  p_drop_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fin && filt_on && !ftype && !rx_ready |=> !rx_ready);

  p_clr_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    filt_clr |=> !filt_on);

  p_held_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready && !rd_stb |=> $stable(rx_data));

  p_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc && rx_ready && !rd_stb |=> rx_ovr);

  p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && !acc |=> !rx_ready && !rx_ovr);
endmodule

bind uart_addr_rx uart_addr_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_bits(cfg_bits), .filt_clr(filt_clr),
  .filt_on(filt_on), .rd_stb(rd_stb), .rx_data(rx_data), .rx_bit9(rx_bit9),
  .rx_ready(rx_ready), .rx_ovr(rx_ovr), .fin(fin), .ftype(ftype), .acc(acc)
);

// File: tb/uart_addr_rx_tb.sv
`timescale 1ns/1ps
module uart_addr_rx_tb;
  localparam int TDIV = 2;
  localparam int BP   = 16 * TDIV;

  logic clk = 1'b0, rst_n = 1'b0, rxd = 1'b1, tick = 1'b0;
  logic [3:0] cfg_bits = 4'd8;
  logic filt_set = 1'b0, filt_clr = 1'b0, rd_stb = 1'b0;
  logic filt_on, rx_bit9, rx_ferr, rx_ready, rx_ovr;
  logic [7:0] rx_data;
  int n_chk = 0, n_bad = 0, tdc = 0;

  always #4 clk = ~clk;

  always @(negedge clk) begin
    tdc  <= (tdc == TDIV - 1) ? 0 : tdc + 1;
    tick <= (tdc == 0);
  end

  uart_addr_rx u_dut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick(tick), .cfg_bits(cfg_bits),
    .filt_set(filt_set), .filt_clr(filt_clr), .filt_on(filt_on), .rd_stb(rd_stb),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_ferr(rx_ferr),
    .rx_ready(rx_ready), .rx_ovr(rx_ovr)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input int nb, input logic stop1);
    rxd = 1'b0; wait_clk(BP);
    for (int i = 0; i < nb; i++) begin
      rxd = d[i]; wait_clk(BP);
    end
    rxd = stop1; wait_clk(BP);
    rxd = 1'b1;  wait_clk(2 * BP);
  endtask

  task automatic pulse_rd;
    rd_stb = 1'b1; wait_clk(1); rd_stb = 1'b0; wait_clk(1);
  endtask

  task automatic set_filter(input logic on);
    if (on) filt_set = 1'b1; else filt_clr = 1'b1;
    wait_clk(1);
    filt_set = 1'b0; filt_clr = 1'b0;
    wait_clk(1);
  endtask

  task automatic t_reset;
    check("R1 ready", rx_ready, 0);
    check("R1 ovr", rx_ovr, 0);
    check("R1 ferr", rx_ferr, 0);
    check("R1 bit9", rx_bit9, 0);
    check("R1 filt", filt_on, 0);
    check("R1 data", rx_data, 0);
  endtask

  task automatic t_sizes;
    logic [8:0] d = 9'h1A5;
    for (int nb = 5; nb <= 9; nb++) begin
      cfg_bits = 4'(nb);
      send(d, nb, 1'b1);
      check("R4 ready", rx_ready, 1);
      check("R2 data", rx_data, int'(d) & ((1 << nb) - 1) & 8'hFF);
      check("R3 bit9", rx_bit9, (nb == 9) ? 1 : 0);
      pulse_rd;
      check("R10 ready cleared", rx_ready, 0);
    end
  endtask

  task automatic t_filter9;
    cfg_bits = 4'd9;
    set_filter(1'b1);
    check("R7 set", filt_on, 1);
    send(9'h033, 9, 1'b1);
    check("R5 drop ready", rx_ready, 0);
    check("R5 drop data", rx_data, 8'hA5);
    check("R5 drop bit9", rx_bit9, 1);
    send(9'h155, 9, 1'b1);
    check("R6 addr ready", rx_ready, 1);
    check("R6 addr data", rx_data, 8'h55);
    check("R3 addr bit9", rx_bit9, 1);
    pulse_rd;
    set_filter(1'b0);
    check("R7 clear", filt_on, 0);
    send(9'h012, 9, 1'b1);
    check("R4 data frame ready", rx_ready, 1);
    check("R4 data frame data", rx_data, 8'h12);
    check("R3 data bit9", rx_bit9, 0);
    pulse_rd;
  endtask

  task automatic t_filter8;
    cfg_bits = 4'd8;
    set_filter(1'b1);
    send(9'h03C, 8, 1'b0);
    check("R5 stop-type drop ready", rx_ready, 0);
    check("R5 stop-type drop data", rx_data, 8'h12);
    send(9'h0C3, 8, 1'b1);
    check("R6 stop-type addr ready", rx_ready, 1);
    check("R6 stop-type addr data", rx_data, 8'hC3);
    check("R8 no ferr", rx_ferr, 0);
    check("R3 bit9 zero", rx_bit9, 0);
    pulse_rd;
    set_filter(1'b0);
  endtask

  task automatic t_ferr;
    cfg_bits = 4'd8;
    send(9'h05A, 8, 1'b0);
    check("R8 ferr 8-bit", rx_ferr, 1);
    check("R4 ready low stop", rx_ready, 1);
    pulse_rd;
    cfg_bits = 4'd9;
    set_filter(1'b1);
    send(9'h1E1, 9, 1'b0);
    check("R8 ferr 9-bit", rx_ferr, 1);
    check("R6 ready", rx_ready, 1);
    pulse_rd;
    send(9'h1E2, 9, 1'b1);
    check("R8 ferr clear", rx_ferr, 0);
    pulse_rd;
    set_filter(1'b0);
  endtask

  task automatic t_overrun;
    cfg_bits = 4'd8;
    send(9'h011, 8, 1'b1);
    send(9'h022, 8, 1'b1);
    check("R9 ovr", rx_ovr, 1);
    check("R9 kept data", rx_data, 8'h11);
    pulse_rd;
    check("R10 ready", rx_ready, 0);
    check("R10 ovr", rx_ovr, 0);
  endtask

  task automatic t_glitch;
    rxd = 1'b0; wait_clk(4 * TDIV);
    rxd = 1'b1; wait_clk(12 * BP);
    check("R11 glitch", rx_ready, 0);
  endtask

  task automatic t_setclr;
    set_filter(1'b1);
    filt_set = 1'b1; filt_clr = 1'b1; wait_clk(1);
    filt_set = 1'b0; filt_clr = 1'b0; wait_clk(1);
    check("R7 clear wins", filt_on, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait_clk(2);
    t_reset;
    rst_n = 1'b1;
    wait_clk(4);
    t_reset;
    t_sizes;
    t_filter9;
    t_filter8;
    t_ferr;
    t_overrun;
    t_glitch;
    t_setclr;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule